// File: doc/BRIEF.md
# Misaligned Load/Store Splitter

This block connects a core-side load/store port to a memory bus that carries only whole, naturally aligned 32-bit words. The bus address is a word address: it is the byte address with its two lowest bits dropped. The core may ask for a byte, a halfword or a word at any byte address. If the requested bytes all lie inside one aligned word, the block runs a single bus beat. On a load it right-justifies the wanted bytes. On a store it places the data in the correct byte lanes and enables only those lanes.

When the bytes straddle two aligned words, the `split_en` mode input, sampled when the request is accepted, selects one of two behaviours. In split mode the block runs two beats, the lower word first and then the next word. For a load it joins the two halves by shifting the lower word right, shifting the upper word left, and ORing the two. In fault mode the block answers at once with a fault flag and puts nothing on the bus.

The controller has four states. `ST_IDLE` waits for a request. `ST_LO` runs the beat on the lower (or only) word. `ST_HI` runs the beat on the following word. `ST_RESP` pulses the response. The transitions are:
- `ST_IDLE` goes to `ST_LO` when an accepted request needs bus traffic.
- `ST_IDLE` goes to `ST_RESP` when an accepted request faults.
- `ST_LO` goes to `ST_HI` when its beat completes and the access crosses a word.
- `ST_LO` goes to `ST_RESP` when its beat completes and the access fits in one word.
- `ST_HI` goes to `ST_RESP` when its beat completes.
- `ST_RESP` always goes back to `ST_IDLE`.

Top module: `lsb_split_bridge`

## Requirements
- R1: After reset the block is idle: `req_ready`=1, `bus_valid`=0, `rsp_done`=0, `rsp_fault`=0.
- R2: `req_size` encodes 0=byte, 1=halfword, 2=word. Bit k of `bus_be` enables byte lane k, which is `bus_wdata`/`bus_rdata` bits 8k+7..8k, and byte address 4*`bus_addr`+k (little-endian). An access whose offset plus size is at most 4 runs exactly one beat at `bus_addr` = `req_addr[31:2]`, with `bus_be` = size mask (0001, 0011, 1111) shifted left by the offset `req_addr[1:0]`.
- R3: A load returns its bytes right-justified, with the lowest address in bits 7..0. Byte and halfword results are zero-extended when `req_signed`=0 and sign-extended when `req_signed`=1.
- R4: In split mode a word-crossing access runs two beats: first at `req_addr[31:2]`, then at `req_addr[31:2]`+1. The load result is (lower word >> 8*offset) | (upper word << 8*(4-offset)), followed by the extension rule of R3.
- R5: A split store enables lanes offset..3 in the first beat and lanes 0..(offset+size-5) in the second. Each enabled lane carries the matching byte of `req_wdata`. No other byte of memory changes.
- R6: With `split_en`=0, a word-crossing access gives `rsp_done`=1 with `rsp_fault`=1 in the cycle after acceptance, and `bus_valid` never rises. A non-crossing access in this mode completes normally with `rsp_fault`=0.
- R7: A beat completes on a clock edge where `bus_valid` and `bus_ready` are both 1. Until then `bus_addr`, `bus_be`, `bus_wdata` and `bus_write` hold steady.
- R8: `rsp_done` is high for exactly one cycle, the cycle after the last beat completes. With w wait cycles per beat, it is seen beats*(1+w)+1 cycles after acceptance.
- R9: `req_ready` is 1 only when idle. `req_valid` and the request fields are ignored while a transaction is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Core request present |
| req_ready | output | 1 | Block is idle and takes the request |
| req_addr | input | 32 | Byte address |
| req_write | input | 1 | 1 = store, 0 = load |
| req_size | input | 2 | 0 byte, 1 halfword, 2 word |
| req_signed | input | 1 | Sign-extend a narrow load |
| req_wdata | input | 32 | Store data, right-justified |
| split_en | input | 1 | 1 = split crossing accesses, 0 = fault on them |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_fault | output | 1 | Misalignment fault, valid with rsp_done |
| rsp_rdata | output | 32 | Load result, valid with rsp_done |
| bus_valid | output | 1 | Beat request |
| bus_ready | input | 1 | Memory accepts the beat |
| bus_addr | output | 30 | Word address |
| bus_write | output | 1 | Beat is a write |
| bus_be | output | 4 | Byte-lane enables |
| bus_wdata | output | 32 | Write data in lane position |
| bus_rdata | input | 32 | Read word, sampled at the completing edge |

## Verification
The response is due a fixed number of cycles after the accepting edge. A fault arrives one cycle after acceptance. A single beat with w wait cycles arrives after (1+w)+1 cycles, and a split access after 2*(1+w)+1 cycles.

The bench counts the falling edges from acceptance until `rsp_done`, compares that count with the formula, and checks one edge later that the pulse has ended. Every beat is logged at the completing edge, and its word address, lanes and data are compared in order. Load data are read at the falling edge on which `rsp_done` is seen. Stores are checked by reading the affected words back with aligned loads, against a byte-level model kept in the bench.

// File: rtl/lsb_pkg.sv
package lsb_pkg;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2
    } size_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LO,
        ST_HI,
        ST_RESP
    } state_e;

endpackage

// File: rtl/lsb_plan.sv
// Decodes an access into its offset, byte count, word-crossing flag,
// the two word addresses and the lane enables of each beat.
module lsb_plan #(
    parameter  int ADDR_W  = 32,
    parameter  int LANES   = 4,
    localparam int OFF_W   = $clog2(LANES),
    localparam int WADDR_W = ADDR_W - OFF_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ADDR_W-1:0]  addr,
    input  logic [1:0]         size,
    output logic [OFF_W-1:0]   off,
    output logic [OFF_W:0]     nbytes,
    output logic               crosses,
    output logic [WADDR_W-1:0] word_lo,
    output logic [WADDR_W-1:0] word_hi,
    output logic [LANES-1:0]   be_lo,
    output logic [LANES-1:0]   be_hi
);
    import lsb_pkg::*;

    logic [2*LANES-1:0] span;

    always_comb begin
        off = addr[OFF_W-1:0];
        unique case (size_e'(size))
            SZ_BYTE: nbytes = (OFF_W+1)'(1);
            SZ_HALF: nbytes = (OFF_W+1)'(2);
            default: nbytes = (OFF_W+1)'(LANES);
        endcase
        span    = ((2*LANES)'(1) << nbytes) - (2*LANES)'(1);
        span    = span << off;
        be_lo   = span[LANES-1:0];
        be_hi   = span[2*LANES-1:LANES];
        crosses = (int'(off) + int'(nbytes)) > LANES;
        word_lo = addr[ADDR_W-1:OFF_W];
        word_hi = word_lo + 1'b1;
    end

    AST_LANE_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({be_hi, be_lo}) == int'(nbytes)); // R2
    AST_CROSS_LANES: assert property (@(posedge clk) disable iff (!rst_n)
        crosses |-> (be_lo[LANES-1] && be_hi[0])); // R5

endmodule

// File: rtl/lsb_store_align.sv
// Moves right-justified store data into lane position across two beats.
module lsb_store_align #(
    parameter  int LANES  = 4,
    localparam int OFF_W  = $clog2(LANES),
    localparam int DATA_W = 8 * LANES
) (
    input  logic [DATA_W-1:0] wdata,
    input  logic [OFF_W-1:0]  off,
    output logic [DATA_W-1:0] wd_lo,
    output logic [DATA_W-1:0] wd_hi
);
    logic [2*DATA_W-1:0] wide;

    always_comb begin
        wide  = {{DATA_W{1'b0}}, wdata} << (8 * int'(off));
        wd_lo = wide[DATA_W-1:0];
        wd_hi = wide[2*DATA_W-1:DATA_W];
    end

endmodule

// File: rtl/lsb_load_merge.sv
// Joins the lower and upper words of a load and extends the result.
module lsb_load_merge #(
    parameter  int LANES  = 4,
    localparam int OFF_W  = $clog2(LANES),
    localparam int DATA_W = 8 * LANES
) (
    input  logic [DATA_W-1:0] lo_word,
    input  logic [DATA_W-1:0] hi_word,
    input  logic [OFF_W-1:0]  off,
    input  logic              crosses,
    input  logic [OFF_W:0]    nbytes,
    input  logic              sgn,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] lo_part;
    logic [DATA_W-1:0] hi_part;
    logic [DATA_W-1:0] raw;
    logic              fill;

    always_comb begin
        lo_part = lo_word >> (8 * int'(off));
        hi_part = crosses ? (hi_word << (8 * (LANES - int'(off)))) : '0;
        raw     = lo_part | hi_part;
        fill    = 1'b0;
        for (int k = 0; k < LANES; k++) begin
            if (k == int'(nbytes) - 1) fill = sgn & raw[8*k+7];
        end
        for (int k = 0; k < LANES; k++) begin
            rdata[8*k +: 8] = (k < int'(nbytes)) ? raw[8*k +: 8] : {8{fill}};
        end
    end

endmodule

// File: rtl/lsb_split_bridge.sv
module lsb_split_bridge #(
    parameter  int ADDR_W  = 32,
    parameter  int DATA_W  = 32,
    localparam int LANES   = DATA_W / 8,
    localparam int OFF_W   = $clog2(LANES),
    localparam int WADDR_W = ADDR_W - OFF_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic [ADDR_W-1:0]  req_addr,
    input  logic               req_write,
    input  logic [1:0]         req_size,
    input  logic               req_signed,
    input  logic [DATA_W-1:0]  req_wdata,
    input  logic               split_en,
    output logic               rsp_done,
    output logic               rsp_fault,
    output logic [DATA_W-1:0]  rsp_rdata,
    output logic               bus_valid,
    input  logic               bus_ready,
    output logic [WADDR_W-1:0] bus_addr,
    output logic               bus_write,
    output logic [LANES-1:0]   bus_be,
    output logic [DATA_W-1:0]  bus_wdata,
    input  logic [DATA_W-1:0]  bus_rdata
);
    import lsb_pkg::*;

    state_e              state_q, state_d;
    logic [ADDR_W-1:0]   addr_q;
    logic [1:0]          size_q;
    logic                write_q, sgn_q, fault_q;
    logic [DATA_W-1:0]   wdata_q, lo_q, hi_q;

    logic                accept, beat_done;
    logic [ADDR_W-1:0]   plan_addr;
    logic [1:0]          plan_size;
    logic [OFF_W-1:0]    off;
    logic [OFF_W:0]      nbytes;
    logic                crosses;
    logic [WADDR_W-1:0]  word_lo, word_hi;
    logic [LANES-1:0]    be_lo, be_hi;
    logic [DATA_W-1:0]   wd_lo, wd_hi, merged;

    assign accept    = req_valid && (state_q == ST_IDLE);
    assign beat_done = bus_valid && bus_ready;
    assign plan_addr = (state_q == ST_IDLE) ? req_addr : addr_q;
    assign plan_size = (state_q == ST_IDLE) ? req_size : size_q;

    lsb_plan #(.ADDR_W(ADDR_W), .LANES(LANES)) u_plan (
        .clk     (clk),
        .rst_n   (rst_n),
        .addr    (plan_addr),
        .size    (plan_size),
        .off     (off),
        .nbytes  (nbytes),
        .crosses (crosses),
        .word_lo (word_lo),
        .word_hi (word_hi),
        .be_lo   (be_lo),
        .be_hi   (be_hi)
    );

    lsb_store_align #(.LANES(LANES)) u_align (
        .wdata (wdata_q),
        .off   (off),
        .wd_lo (wd_lo),
        .wd_hi (wd_hi)
    );

    lsb_load_merge #(.LANES(LANES)) u_merge (
        .lo_word (lo_q),
        .hi_word (hi_q),
        .off     (off),
        .crosses (crosses),
        .nbytes  (nbytes),
        .sgn     (sgn_q),
        .rdata   (merged)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (accept) state_d = (crosses && !split_en) ? ST_RESP : ST_LO;
            ST_LO:   if (beat_done) state_d = crosses ? ST_HI : ST_RESP;
            ST_HI:   if (beat_done) state_d = ST_RESP;
            ST_RESP: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // Request capture and read-word capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q  <= '0;
            size_q  <= '0;
            write_q <= 1'b0;
            sgn_q   <= 1'b0;
            fault_q <= 1'b0;
            wdata_q <= '0;
            lo_q    <= '0;
            hi_q    <= '0;
        end else begin
            if (accept) begin
                addr_q  <= req_addr;
                size_q  <= req_size;
                write_q <= req_write;
                sgn_q   <= req_signed;
                wdata_q <= req_wdata;
                fault_q <= crosses && !split_en;
            end
            if (beat_done && !write_q && state_q == ST_LO) lo_q <= bus_rdata;
            if (beat_done && !write_q && state_q == ST_HI) hi_q <= bus_rdata;
        end
    end

    // Outputs
    always_comb begin
        req_ready = 1'b0;
        bus_valid = 1'b0;
        bus_addr  = word_lo;
        bus_be    = be_lo;
        bus_wdata = wd_lo;
        bus_write = 1'b0;
        rsp_done  = 1'b0;
        rsp_fault = 1'b0;
        rsp_rdata = '0;
        unique case (state_q)
            ST_IDLE: req_ready = 1'b1;
            ST_LO: begin
                bus_valid = 1'b1;
                bus_write = write_q;
            end
            ST_HI: begin
                bus_valid = 1'b1;
                bus_write = write_q;
                bus_addr  = word_hi;
                bus_be    = be_hi;
                bus_wdata = wd_hi;
            end
            ST_RESP: begin
                rsp_done  = 1'b1;
                rsp_fault = fault_q;
                if (!write_q && !fault_q) rsp_rdata = merged;
            end
            default: ;
        endcase
    end

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (!bus_valid && !rsp_done)); // R9
    AST_BEAT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && !bus_ready) |=> (bus_valid && $stable(bus_addr) && $stable(bus_be)
                                       && $stable(bus_wdata) && $stable(bus_write))); // R7
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |=> !rsp_done); // R8
    AST_FAULT_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_fault |-> $past(req_valid && req_ready)); // R6
    AST_HI_NEXT_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_done && state_q == ST_LO && crosses)
            |=> (bus_valid && bus_addr == WADDR_W'($past(bus_addr) + 1'b1))); // R4
    AST_LANES_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
        bus_valid |-> (|bus_be)); // R5

endmodule

// File: tb/lsb_split_bridge_bench.sv
module lsb_split_bridge_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_addr = '0;
    logic        req_write = 1'b0;
    logic [1:0]  req_size = '0;
    logic        req_signed = 1'b0;
    logic [31:0] req_wdata = '0;
    logic        split_en = 1'b1;
    logic        rsp_done, rsp_fault;
    logic [31:0] rsp_rdata;
    logic        bus_valid, bus_ready, bus_write;
    logic [29:0] bus_addr;
    logic [3:0]  bus_be;
    logic [31:0] bus_wdata, bus_rdata;

    int checks = 0;
    int errors = 0;
    bit ended  = 0;
    int ws     = 0;
    int wcnt   = 0;
    int nb     = 0;

    logic [31:0] mem    [0:15];
    logic [7:0]  shadow [0:63];
    logic [29:0] lg_addr [0:63];
    logic [3:0]  lg_be   [0:63];
    logic [31:0] lg_wd   [0:63];

    always #4 clk = ~clk;

    lsb_split_bridge u_lsb_split_bridge (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
        .req_write(req_write), .req_size(req_size), .req_signed(req_signed),
        .req_wdata(req_wdata), .split_en(split_en),
        .rsp_done(rsp_done), .rsp_fault(rsp_fault), .rsp_rdata(rsp_rdata),
        .bus_valid(bus_valid), .bus_ready(bus_ready), .bus_addr(bus_addr),
        .bus_write(bus_write), .bus_be(bus_be), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata)
    );

    // Memory model with programmable wait cycles per beat
    assign bus_ready = bus_valid && (wcnt >= ws);
    assign bus_rdata = mem[bus_addr[3:0]];

    always @(posedge clk) begin
        if (!rst_n) wcnt <= 0;
        else if (bus_valid && bus_ready) wcnt <= 0;
        else if (bus_valid) wcnt <= wcnt + 1;
        if (rst_n && bus_valid && bus_ready) begin
            lg_addr[nb % 64] <= bus_addr;
            lg_be[nb % 64]   <= bus_be;
            lg_wd[nb % 64]   <= bus_wdata;
            nb <= nb + 1;
            if (bus_write)
                for (int k = 0; k < 4; k++)
                    if (bus_be[k]) mem[bus_addr[3:0]][8*k +: 8] <= bus_wdata[8*k +: 8];
        end
    end

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_load(int addr, int size, bit sgn);
        int n = (size == 0) ? 1 : (size == 1) ? 2 : 4;
        logic [31:0] v = '0;
        for (int k = 0; k < n; k++) v[8*k +: 8] = shadow[(addr + k) % 64];
        if (sgn && n < 4 && v[8*n-1])
            for (int k = 8*n; k < 32; k++) v[k] = 1'b1;
        return v;
    endfunction

    task automatic chk_beat(int idx, int exp_addr, logic [3:0] exp_be, logic [31:0] exp_wd,
                            bit is_wr, string tag);
        chk({tag, " beat addr"}, 32'(lg_addr[idx % 64]), 32'(exp_addr));
        chk({tag, " beat lanes"}, 32'(lg_be[idx % 64]), 32'(exp_be));
        if (is_wr) chk({tag, " beat data"}, lg_wd[idx % 64], exp_wd);
    endtask

    // One transaction: drive, time the response, check latency, pulse, fault, beats, data
    task automatic do_req(int addr, bit wr, int size, bit sgn, logic [31:0] wd, bit split,
                          int wsv, int exp_beats, bit exp_fault, string tag, output int base);
        int n;
        int lat;
        logic [31:0] expd;
        @(negedge clk);
        ws = wsv; split_en = split;
        req_addr = 32'(addr); req_write = wr; req_size = 2'(size);
        req_signed = sgn; req_wdata = wd; req_valid = 1'b1;
        base = nb;
        expd = exp_load(addr, size, sgn);
        chk("R9 ready while idle", 32'(req_ready), 32'd1);
        @(negedge clk);
        req_valid = 1'b0;
        n = 1;
        while (!rsp_done && n < 40) begin
            @(negedge clk);
            n++;
        end
        lat = exp_fault ? 1 : exp_beats * (1 + wsv) + 1;
        chk({"R8 latency ", tag}, 32'(n), 32'(lat));
        chk({"R6 fault flag ", tag}, 32'(rsp_fault), 32'(exp_fault));
        if (!wr && !exp_fault) chk({"R3 load data ", tag}, rsp_rdata, expd);
        if (wr && !exp_fault) begin
            int nbyt = (size == 0) ? 1 : (size == 1) ? 2 : 4;
            for (int k = 0; k < nbyt; k++) shadow[(addr + k) % 64] = wd[8*k +: 8];
        end
        @(negedge clk);
        chk({"R8 done pulse ", tag}, 32'(rsp_done), 32'd0);
        chk({"R2 beat count ", tag}, 32'(nb - base), 32'(exp_beats));
    endtask

    task automatic t_reset();
        chk("R1 ready", 32'(req_ready), 32'd1);
        chk("R1 bus idle", 32'(bus_valid), 32'd0);
        chk("R1 done low", 32'(rsp_done), 32'd0);
        chk("R1 fault low", 32'(rsp_fault), 32'd0);
    endtask

    task automatic t_single_beat();
        int b;
        do_req(8, 0, 2, 0, 0, 1, 0, 1, 0, "R2 word@8", b);
        chk_beat(b, 2, 4'b1111, 0, 0, "R2 word@8");
        do_req(5, 0, 1, 0, 0, 1, 1, 1, 0, "R3 half@5 zx", b);
        chk_beat(b, 1, 4'b0110, 0, 0, "R2 half@5");
        do_req(2, 0, 1, 1, 0, 1, 0, 1, 0, "R3 half@2 sx", b);
        do_req(2, 0, 1, 0, 0, 1, 0, 1, 0, "R3 half@2 zx", b);
        do_req(7, 0, 0, 1, 0, 1, 2, 1, 0, "R3 byte@7 sx", b);
        chk_beat(b, 1, 4'b1000, 0, 0, "R2 byte@7");
    endtask

    task automatic t_split_loads();
        int b;
        do_req(1, 0, 2, 0, 0, 1, 2, 2, 0, "R4 word@1", b);
        chk_beat(b, 0, 4'b1110, 0, 0, "R4 word@1 lo");
        chk_beat(b + 1, 1, 4'b0001, 0, 0, "R4 word@1 hi");
        do_req(7, 0, 1, 1, 0, 1, 0, 2, 0, "R4 half@7 sx", b);
        chk_beat(b, 1, 4'b1000, 0, 0, "R4 half@7 lo");
        chk_beat(b + 1, 2, 4'b0001, 0, 0, "R4 half@7 hi");
        do_req(11, 0, 2, 0, 0, 1, 1, 2, 0, "R4 word@11", b);
    endtask

    task automatic t_stores();
        int b;
        do_req(6, 1, 2, 0, 32'hDEADBEEF, 1, 1, 2, 0, "R5 store word@6", b);
        chk_beat(b, 1, 4'b1100, 32'hBEEF0000, 1, "R5 store lo");
        chk_beat(b + 1, 2, 4'b0011, 32'h0000DEAD, 1, "R5 store hi");
        do_req(4, 0, 2, 0, 0, 1, 0, 1, 0, "R5 readback@4", b);
        do_req(8, 0, 2, 0, 0, 1, 0, 1, 0, "R5 readback@8", b);
        do_req(13, 1, 0, 0, 32'h0000005A, 1, 0, 1, 0, "R2 store byte@13", b);
        chk_beat(b, 3, 4'b0010, 32'h00005A00, 1, "R2 store byte@13");
        do_req(12, 0, 2, 0, 0, 1, 0, 1, 0, "R2 readback@12", b);
    endtask

    task automatic t_fault_mode();
        int b;
        do_req(2, 0, 2, 0, 0, 0, 0, 0, 1, "R6 word@2 fault", b);
        do_req(3, 1, 1, 0, 32'h00001234, 0, 0, 0, 1, "R6 store half@3 fault", b);
        do_req(0, 0, 2, 0, 0, 1, 0, 1, 0, "R6 unchanged@0", b);
        do_req(4, 0, 2, 0, 0, 1, 0, 1, 0, "R6 unchanged@4", b);
        do_req(2, 0, 1, 1, 0, 0, 0, 1, 0, "R6 half@2 no fault", b);
    endtask

    task automatic t_busy_ignore();
        int base;
        int n;
        logic [29:0] a1;
        @(negedge clk);
        ws = 3; split_en = 1'b1;
        req_addr = 32'd12; req_write = 1'b0; req_size = 2'd2; req_signed = 1'b0;
        req_valid = 1'b1;
        base = nb;
        @(negedge clk);
        req_addr = 32'd40; req_write = 1'b1; req_wdata = 32'hFFFFFFFF;
        chk("R9 not ready while busy", 32'(req_ready), 32'd0);
        a1 = bus_addr;
        @(negedge clk);
        chk("R9 not ready while busy", 32'(req_ready), 32'd0);
        @(negedge clk);
        chk("R7 addr held in wait", 32'(bus_addr), 32'(a1));
        chk("R7 valid held in wait", 32'(bus_valid), 32'd1);
        req_valid = 1'b0;
        n = 3;
        while (!rsp_done && n < 40) begin
            @(negedge clk);
            n++;
        end
        chk("R8 latency busy", 32'(n), 32'd5);
        chk("R9 load data busy", rsp_rdata, exp_load(12, 2, 0));
        @(negedge clk);
        chk("R9 one beat only", 32'(nb - base), 32'd1);
        chk("R9 beat addr", 32'(lg_addr[base % 64]), 32'd3);
        chk("R9 word@40 untouched", mem[10], {shadow[43], shadow[42], shadow[41], shadow[40]});
    endtask

    initial begin
        for (int bb = 0; bb < 64; bb++) shadow[bb] = 8'(bb * 37 + 133);
        for (int w = 0; w < 16; w++)
            mem[w] = {shadow[4*w+3], shadow[4*w+2], shadow[4*w+1], shadow[4*w]};
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_single_beat();
        t_split_loads();
        t_stores();
        t_fault_mode();
        t_busy_ignore();
        if (!ended) begin
            ended = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!ended) begin
            ended = 1;
            checks++;
            errors++;
            $display("FAIL R8 watchdog act=running exp=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule